// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller Core

This block collects fifteen interrupt request lines, numbered 1 to 15, and presents one interrupt level to each of up to sixteen processors. It keeps one pending register that all processors share. Each processor also has its own enable mask and its own force register. A priority-class register splits the lines into a high class and a low class. For each processor, the block looks at the lines that are both requested and enabled. It picks the highest-numbered one, taking it from the high class when that class has any candidate. The block drives the chosen line number on a 4-bit registered output, or 0 when there is no candidate.

A line can also be marked for broadcast. An asserted broadcast line does not go into the shared pending register. It sets its bit in the force register of every processor, so each processor serves its own copy. A processor returns the level it served on its acknowledge port. This clears that level from the shared pending register and from that processor's force register. Software works the block through a word-wide register bus that completes in a single cycle. Writes take effect at the next clock edge, and reads return the current state combinationally.

The register decoder sorts each bus address into one of nine classes: class-select, pending, force alias, clear, broadcast, mask, force, extended and unmapped. The read multiplexer and the write logic each choose their action through a `unique case` on that class. The block has no sequencing state machine; every register updates in the same cycle as the write.

Top module: `mp_irq_ctrl`

## Requirements
- R1: After reset, the level, pending, broadcast, mask, force and extended registers are all zero. Every register reads back 0, and every processor level output is 0.
- R2: An input line k (1..15) that is high on a clock edge, and whose broadcast bit is 0, sets pending bit k. Input bit 0 is ignored. Writes to the pending register (byte address 0x04) have no effect.
- R3: An input line k that is high, and whose broadcast bit (address 0x14, bit k) is 1, sets bit k of every processor's force register and leaves pending bit k unchanged.
- R4: A processor n's candidate set is (pending OR force[n]) AND mask[n]. Its output is the highest-numbered candidate among the lines whose class bit (address 0x00, bit k) is 1. If there is none, it is the highest-numbered candidate among the lines whose class bit is 0. If there are no candidates at all, the output is 0.
- R5: An acknowledge from processor n with level L (1..15) clears pending bit L and bit L of force[n] only. An acknowledge with level 0 changes nothing.
- R6: A write to the clear register (address 0x0C) clears, for each set bit k in 15:1, pending bit k and bit k of every force register. The clear register always reads 0.
- R7: A write to processor n's force register (address 0x80+4n) first ORs data bits 15:1 into force[n]. It then clears each bit k for which data bit 16+k is set (k in 1..15). A write to address 0x08 replaces force[0] with data bits 15:1, and reading 0x08 returns force[0].
- R8: Bit 0 of every write to the class, mask, force, clear and broadcast registers is dropped. Addresses 0x40+4n hold mask[n]. Addresses 0xC0+4n hold a 4-bit extended value taken from data bits 3:0. Registers of processors at or above the configured count, and all other addresses, read 0 and ignore writes. Address bits 1:0 are ignored.
- R9: State changes at the clock edge that samples the inputs. Each output shows, one edge later, the selection made from that state. When a line is high in the same cycle as an acknowledge or clear of the same bit, the line wins and the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 16 | Interrupt request lines; bit k is line k, bit 0 unused |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the 32-bit register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read |
| ack_valid | input | NCPU | Per-processor acknowledge strobe |
| ack_level | input | NCPU*4 | Per-processor served level, processor n in bits 4n+3:4n |
| irq_level | output | NCPU*4 | Per-processor selected level, processor n in bits 4n+3:4n, 0 = none |

## Verification
The request inputs set bits in the same registers that the acknowledge port and the clear register are clearing. The two can therefore reach the same bit in the same cycle. The bench provokes this on purpose: it holds a line high in the very cycle that a processor acknowledges that line, then again in a cycle that writes the clear register for it. A long random phase also overlaps input pulses, acknowledges and force-register writes with no coordination between them. A behavioural reference model judges each such cycle by applying the bus write, then the clears, then the input sets, and compares the read data and every processor's level on every clock.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
    localparam int LINES = 16;
    localparam int LW    = $clog2(LINES);
    localparam int EXTW  = 4;
    localparam logic [LINES-1:0] LINE_MASK = {{(LINES-1){1'b1}}, 1'b0};

    typedef enum logic [3:0] {
        REG_CLASS,
        REG_PEND,
        REG_FALIAS,
        REG_CLEAR,
        REG_BCAST,
        REG_MASK,
        REG_FORCE,
        REG_EXT,
        REG_NONE
    } reg_kind_e;

    function automatic logic [LINES-1:0] line_bit(input logic [LW-1:0] lvl);
        logic [LINES-1:0] v;
        v = '0;
        v[lvl] = 1'b1;
        return v & LINE_MASK;
    endfunction
endpackage

// File: rtl/mpic_addr_dec.sv
module mpic_addr_dec
    import mpic_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic [7:0] addr,
    output reg_kind_e  kind,
    output logic [3:0] idx,
    output logic       idx_ok
);
    assign idx    = addr[5:2];
    assign idx_ok = (int'(idx) < NCPU);

    always_comb begin
        kind = REG_NONE;
        unique case (addr[7:6])
            2'b00: begin
                unique case (addr[5:2])
                    4'd0:    kind = REG_CLASS;
                    4'd1:    kind = REG_PEND;
                    4'd2:    kind = REG_FALIAS;
                    4'd3:    kind = REG_CLEAR;
                    4'd5:    kind = REG_BCAST;
                    default: kind = REG_NONE;
                endcase
            end
            2'b01:   kind = REG_MASK;
            2'b10:   kind = REG_FORCE;
            2'b11:   kind = REG_EXT;
            default: kind = REG_NONE;
        endcase
    end
endmodule

// File: rtl/mpic_pick.sv
module mpic_pick
    import mpic_pkg::*;
(
    input  logic [LINES-1:0] cand,
    input  logic [LINES-1:0] hi_class,
    output logic [LW-1:0]    lvl
);
    logic [LINES-1:0] hi_set;
    logic [LINES-1:0] pool;

    assign hi_set = cand & hi_class & LINE_MASK;
    assign pool   = (|hi_set) ? hi_set : (cand & ~hi_class & LINE_MASK);

    always_comb begin
        lvl = '0;
        for (int i = 1; i < LINES; i++) begin
            if (pool[i]) lvl = LW'(i);
        end
    end
endmodule

// File: rtl/mp_irq_ctrl.sv
module mp_irq_ctrl
    import mpic_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       irq_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NCPU-1:0]   ack_valid,
    input  logic [NCPU*4-1:0] ack_level,
    output logic [NCPU*4-1:0] irq_level
);
    localparam int CIW = (NCPU > 1) ? $clog2(NCPU) : 1;

    reg_kind_e   kind;
    logic [3:0]  idx;
    logic        idx_ok;
    logic        wr_en;

    logic [LINES-1:0] class_q, pend_q, bcast_q;
    logic [LINES-1:0] class_d, pend_d, bcast_d;
    logic [LINES-1:0] mask_q  [NCPU];
    logic [LINES-1:0] mask_d  [NCPU];
    logic [LINES-1:0] force_q [NCPU];
    logic [LINES-1:0] force_d [NCPU];
    logic [EXTW-1:0]  ext_q   [NCPU];
    logic [EXTW-1:0]  ext_d   [NCPU];
    logic [LINES-1:0] ack_vec [NCPU];
    logic [LINES-1:0] cand    [NCPU];
    logic [LW-1:0]    pick_lvl[NCPU];

    logic [LINES-1:0] set_vec, clr_vec, ack_any;
    logic [LINES-1:0] wlo, whi;
    logic             unused_bits;

    assign unused_bits = ^{bus_addr[1:0], bus_wdata[16]};

    mpic_addr_dec #(.NCPU(NCPU)) u_dec (
        .addr   (bus_addr),
        .kind   (kind),
        .idx    (idx),
        .idx_ok (idx_ok)
    );

    assign wr_en   = bus_sel && bus_wr;
    assign wlo     = bus_wdata[15:0] & LINE_MASK;
    assign whi     = bus_wdata[31:16] & LINE_MASK;
    assign set_vec = irq_in & LINE_MASK;
    assign clr_vec = (wr_en && kind == REG_CLEAR) ? wlo : '0;

    // acknowledge decode, one vector per processor
    always_comb begin
        ack_any = '0;
        for (int n = 0; n < NCPU; n++) begin
            ack_vec[n] = ack_valid[n] ? line_bit(ack_level[4*n +: 4]) : '0;
            ack_any    = ack_any | ack_vec[n];
        end
    end

    // shared registers: bus write, then clears, then line sets
    always_comb begin
        class_d = class_q;
        bcast_d = bcast_q;
        if (wr_en && kind == REG_CLASS) class_d = wlo;
        if (wr_en && kind == REG_BCAST) bcast_d = wlo;
        pend_d = (pend_q & ~clr_vec & ~ack_any) | (set_vec & ~bcast_q);
    end

    // per-processor registers
    always_comb begin
        for (int n = 0; n < NCPU; n++) begin
            mask_d[n]  = mask_q[n];
            ext_d[n]   = ext_q[n];
            force_d[n] = force_q[n];
            if (wr_en && idx_ok && idx == 4'(n)) begin
                unique case (kind)
                    REG_MASK:  mask_d[n]  = wlo;
                    REG_EXT:   ext_d[n]   = bus_wdata[EXTW-1:0];
                    REG_FORCE: force_d[n] = (force_q[n] | wlo) & ~whi;
                    default: ;
                endcase
            end
            if (n == 0 && wr_en && kind == REG_FALIAS) force_d[n] = wlo;
            force_d[n] = (force_d[n] & ~clr_vec & ~ack_vec[n]) | (set_vec & bcast_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            class_q <= '0;
            pend_q  <= '0;
            bcast_q <= '0;
            for (int n = 0; n < NCPU; n++) begin
                mask_q[n]  <= '0;
                force_q[n] <= '0;
                ext_q[n]   <= '0;
            end
        end else begin
            class_q <= class_d;
            pend_q  <= pend_d;
            bcast_q <= bcast_d;
            for (int n = 0; n < NCPU; n++) begin
                mask_q[n]  <= mask_d[n];
                force_q[n] <= force_d[n];
                ext_q[n]   <= ext_d[n];
            end
        end
    end

    // selection per processor
    generate
        for (genvar g = 0; g < NCPU; g++) begin : g_cpu
            assign cand[g] = (pend_q | force_q[g]) & mask_q[g];

            mpic_pick u_pick (
                .cand     (cand[g]),
                .hi_class (class_q),
                .lvl      (pick_lvl[g])
            );

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) irq_level[4*g +: 4] <= '0;
                else        irq_level[4*g +: 4] <= pick_lvl[g];
            end

            assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (cand[g] == '0) |=> (irq_level[4*g +: 4] == '0));

            assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_vec[g] != '0 && (set_vec & ack_vec[g]) == '0 && !wr_en)
                |=> ((force_q[g] & $past(ack_vec[g])) == '0));
        end
    endgenerate

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (kind)
                REG_CLASS:  bus_rdata[LINES-1:0] = class_q;
                REG_PEND:   bus_rdata[LINES-1:0] = pend_q;
                REG_FALIAS: bus_rdata[LINES-1:0] = force_q[0];
                REG_BCAST:  bus_rdata[LINES-1:0] = bcast_q;
                REG_MASK:   if (idx_ok) bus_rdata[LINES-1:0] = mask_q[idx[CIW-1:0]];
                REG_FORCE:  if (idx_ok) bus_rdata[LINES-1:0] = force_q[idx[CIW-1:0]];
                REG_EXT:    if (idx_ok) bus_rdata[EXTW-1:0]  = ext_q[idx[CIW-1:0]];
                default:    bus_rdata = '0;
            endcase
        end
    end

    assert_pend_readonly_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == REG_PEND && set_vec == '0 && ack_valid == '0) |=> $stable(pend_q));

    assert_clear_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == REG_CLEAR && set_vec == '0) |=> ((pend_q & $past(clr_vec)) == '0));

    assert_input_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_vec & ~bcast_q) != '0)
        |=> ((pend_q & $past(set_vec & ~bcast_q)) == $past(set_vec & ~bcast_q)));
endmodule

// File: tb/mp_irq_ctrl_bench.sv
module mp_irq_ctrl_bench;
    localparam int NCPU = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       irq_in = '0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCPU-1:0]   ack_valid = '0;
    logic [NCPU*4-1:0] ack_level = '0;
    logic [NCPU*4-1:0] irq_level;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";

    int unsigned m_cls, m_pend, m_bc;
    int unsigned m_mask[NCPU];
    int unsigned m_force[NCPU];
    int unsigned m_ext[NCPU];
    int unsigned m_out[NCPU];

    always #4 clk = ~clk;

    mp_irq_ctrl #(.NCPU(NCPU)) u_mp_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ack_valid(ack_valid), .ack_level(ack_level), .irq_level(irq_level)
    );

    function automatic int unsigned pick(int n);
        int unsigned c, hi;
        c  = (m_pend | m_force[n]) & m_mask[n];
        hi = c & m_cls;
        if (hi == 0) hi = c & ~m_cls;
        for (int k = 15; k >= 1; k--) if ((hi >> k) & 1) return k;
        return 0;
    endfunction

    function automatic int unsigned model_read(int unsigned a);
        int unsigned w, n;
        w = a & 'hFC;
        n = (w & 'h3F) / 4;
        if (w == 'h00) return m_cls;
        if (w == 'h04) return m_pend;
        if (w == 'h08) return m_force[0];
        if (w == 'h14) return m_bc;
        if (w >= 'h40 && n < NCPU) begin
            if (w < 'h80) return m_mask[n];
            if (w < 'hC0) return m_force[n];
            return m_ext[n];
        end
        return 0;
    endfunction

    // reference model, updated on each rising edge from the inputs set one step earlier
    always @(posedge clk) begin
        int unsigned nout[NCPU];
        int unsigned w, n, d, bc_old, s, clr, lv;
        if (!rst_n) begin
            m_cls = 0; m_pend = 0; m_bc = 0;
            for (int i = 0; i < NCPU; i++) begin
                m_mask[i] = 0; m_force[i] = 0; m_ext[i] = 0; m_out[i] = 0;
            end
        end else begin
            for (int i = 0; i < NCPU; i++) nout[i] = pick(i);
            bc_old = m_bc;
            w = bus_addr & 'hFC;
            n = (w & 'h3F) / 4;
            d = bus_wdata;
            clr = 0;
            if (bus_sel && bus_wr) begin
                if (w == 'h00) m_cls = d & 'hFFFE;
                else if (w == 'h08) m_force[0] = d & 'hFFFE;
                else if (w == 'h0C) clr = d & 'hFFFE;
                else if (w == 'h14) m_bc = d & 'hFFFE;
                else if (w >= 'h40 && n < NCPU) begin
                    if (w < 'h80) m_mask[n] = d & 'hFFFE;
                    else if (w < 'hC0) m_force[n] = (m_force[n] | (d & 'hFFFE)) & ~((d >> 16) & 'hFFFE);
                    else m_ext[n] = d & 'hF;
                end
            end
            m_pend = m_pend & ~clr;
            for (int i = 0; i < NCPU; i++) m_force[i] = m_force[i] & ~clr;
            for (int i = 0; i < NCPU; i++) begin
                lv = ack_level[4*i +: 4];
                if (ack_valid[i] && lv != 0) begin
                    m_pend = m_pend & ~(32'd1 << lv);
                    m_force[i] = m_force[i] & ~(32'd1 << lv);
                end
            end
            s = irq_in & 'hFFFE;
            m_pend = m_pend | (s & ~bc_old);
            for (int i = 0; i < NCPU; i++) m_force[i] = m_force[i] | (s & bc_old);
            for (int i = 0; i < NCPU; i++) m_out[i] = nout[i];
        end
    end

    task automatic check(string what, int unsigned act, int unsigned exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        for (int i = 0; i < NCPU; i++)
            check($sformatf("irq_level cpu%0d", i), irq_level[4*i +: 4], m_out[i]);
        if (bus_sel && !bus_wr)
            check($sformatf("rdata @%0h", bus_addr), bus_rdata, model_read(bus_addr));
    endtask

    task automatic wr(int unsigned a, int unsigned d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = d;
        step();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(int unsigned a);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'(a);
        step();
        bus_sel = 1'b0;
    endtask

    task automatic pulse(int unsigned lines);
        irq_in = 16'(lines);
        step();
        irq_in = '0;
    endtask

    task automatic ack(int cpu, int unsigned lvl);
        ack_valid[cpu] = 1'b1;
        ack_level[4*cpu +: 4] = 4'(lvl);
        step();
        ack_valid = '0;
    endtask

    task automatic dump_all();
        rd('h00); rd('h04); rd('h08); rd('h0C); rd('h14);
        for (int i = 0; i < NCPU; i++) begin
            rd('h40 + 4*i); rd('h80 + 4*i); rd('hC0 + 4*i);
        end
        step(); step();
    endtask

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        cur_req = "R1";                      // reset state of every register and output
        dump_all();

        cur_req = "R8";                      // bit 0 dropped, extended is 4 bits, unmapped reads 0
        wr('h00, 'hFFFF);
        wr('h14, 'h0001);
        for (int i = 0; i < NCPU; i++) wr('h40 + 4*i, 'h0001);
        wr('hC0, 'hFF); wr('hC5, 'h3);
        wr('h40 + 4*5, 'hFFFF);              // processor beyond the count
        rd('h10); rd('h3C); rd('h54); rd('h01); rd('hC4);
        dump_all();
        wr('h00, 0);

        cur_req = "R2";                      // pending set by lines, write to pending ignored
        pulse('h0025);
        pulse('h0001);
        wr('h04, 'hFFFF);
        rd('h04); rd('h04);

        cur_req = "R4";                      // class priority, masks per processor
        wr('h00, 'h0008);
        wr('h40, 'hFFFE); wr('h44, 'h0030); wr('h48, 'h0000); wr('h4C, 'h0008);
        pulse('h1028);
        step(); step();
        wr('h00, 'h0000);
        step(); step();
        wr('h0C, 'hFFFE);
        step(); step();

        cur_req = "R3";                      // broadcast lines go to every force register
        wr('h14, 'h0600);
        for (int i = 0; i < NCPU; i++) wr('h40 + 4*i, 'hFFFE);
        pulse('h0640);
        dump_all();

        cur_req = "R5";                      // acknowledge clears pending and own force only
        ack(1, 10); ack(0, 0); ack(2, 6);
        step(); step();
        dump_all();

        cur_req = "R6";                      // clear register reaches pending and all forces
        pulse('h0088);
        wr('h0C, 'h0481);
        rd('h0C);
        dump_all();

        cur_req = "R7";                      // force set/clear halves and alias
        wr('h84, 'h0006_1010);
        wr('h84, 'h1000_0100);
        wr('h08, 'h0000_8003);
        wr('h80, 'hFFFF_0002);
        dump_all();

        cur_req = "R9";                      // line wins over acknowledge and clear in same cycle
        wr('h14, 0);
        pulse('h0010);
        irq_in = 'h0010; ack_valid[0] = 1'b1; ack_level[3:0] = 4'd4;
        step();
        irq_in = '0; ack_valid = '0;
        rd('h04);
        irq_in = 'h0010; wr('h0C, 'h0010); irq_in = '0;
        rd('h04); step(); step();

        cur_req = "R4";                      // random mix
        for (int t = 0; t < 3000; t++) begin
            int unsigned r;
            r = $urandom;
            irq_in = ((r & 7) == 0) ? 16'($urandom) & 16'($urandom) : '0;
            for (int i = 0; i < NCPU; i++) begin
                ack_valid[i] = ($urandom % 5) == 0;
                ack_level[4*i +: 4] = ($urandom % 2) ? irq_level[4*i +: 4] : 4'($urandom);
            end
            bus_sel = ((r >> 3) % 3) == 0;
            bus_wr = (r >> 6) & 1;
            case ((r >> 8) % 8)
                0: bus_addr = 8'h00;
                1: bus_addr = 8'h04;
                2: bus_addr = 8'h08;
                3: bus_addr = 8'h0C;
                4: bus_addr = 8'h14;
                5: bus_addr = 8'h40 + 8'(4 * ($urandom % 6));
                6: bus_addr = 8'h80 + 8'(4 * ($urandom % 6));
                default: bus_addr = 8'hC0 + 8'(4 * ($urandom % 6));
            endcase
            bus_wdata = $urandom;
            step();
        end
        irq_in = '0; ack_valid = '0; bus_sel = 1'b0;
        dump_all();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule